// File: doc/BRIEF.md
# TLB Invalidation Command Controller

This block keeps the tag and valid state of a small, fully associative translation cache that is split into two instances of equal size. It gives software a register interface for removing stale entries. Software first picks the instances to act on through a two-bit selection register. It then issues one of two commands. A full flush drops every entry of the selected instances in one cycle. A range flush walks the entries one index per cycle and drops those whose tag falls inside an inclusive window.

A range flush reports that it has finished through a sticky completion flag. Software polls this flag and clears it by writing zero. If software never sees the flag, it can issue a full flush as a fallback. A full flush stops any scan that is under way and takes priority over it. A separate fill port loads a tag into one entry and marks the entry valid. In a real system this port is driven by the translation walker; here the testbench drives it. The valid bits of both instances are brought out as a flat vector, so the lookup side can use them.

Top module: `tlbi_ctrl`

## Requirements
- R1: After reset, every valid bit is 0, the completion flag reads 0, and the selection, window-low and window-high registers read 0.
- R2: The word-addressed register map is as follows. Address 0 is the command register, which reads 0. Address 1 is the selection register (bits 1:0). Address 2 is the window low bound. Address 3 is the window high bound. Address 4 is the completion flag (bit 0). Reads are combinational from `addr`.
- R3: A command write with bit 1 set (for example 0x2 or 0x3) clears every valid bit of the selected instances at that clock edge, and it does not set the completion flag. A command value of 0 changes nothing.
- R4: Selection bit 0 enables instance 0 and selection bit 1 enables instance 1. An instance whose bit is clear is left untouched by both commands. The selection register is sampled when the command is written.
- R5: A command write of 0x1 starts a range flush. During the flush, an entry is invalidated when it is valid and its tag t satisfies low <= t <= high, with both bounds inclusive. All other entries keep their state. The bounds are captured when the command is written.
- R6: The range flush checks index j of each selected instance at the (j+1)-th clock edge after the command edge. The completion flag reads 1 from the ENTRIES-th edge after the command edge onward.
- R7: Writing 0 to the completion register clears the flag. Writing any non-zero value to it has no effect. A new range command also clears the flag.
- R8: A full-flush command issued during a range flush ends the scan. The completion flag is then not set for the abandoned scan.
- R9: A range command issued during a running scan restarts the scan from index 0. The restarted scan uses the window and selection in force at the new command, and completion comes ENTRIES edges after the new command.
- R10: A fill writes the given tag to the given entry and sets its valid bit at the next edge. The fill overrides a scan decision or a full flush that hits the same entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data, combinational from addr |
| fill_en | input | 1 | Entry fill strobe |
| fill_inst | input | 1 | Instance to fill |
| fill_idx | input | IDX_W | Entry index to fill |
| fill_tag | input | TAG_W | Tag value to load |
| valid_o | output | 2*ENTRIES | Valid bits; instance i entry e at bit i*ENTRIES+e |

## Verification
A full flush, a fill and a register write each take effect at the very edge that samples them. The bench therefore drives stimulus half a period before that edge and reads `valid_o` or `rdata` at the falling edge that follows. For a range flush, the bench counts falling edges from the command edge. It expects the completion flag to read 0 after ENTRIES-1 edges and 1 after ENTRIES edges. For a restart, it counts from the second command. For the fill race, the fill is placed on exactly the edge where the scan visits that index.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;
   // number of cache instances, one selection bit each
   localparam int unsigned NUM_INST = 2;

   // word addresses of the register map
   localparam int unsigned REG_CMD  = 0;
   localparam int unsigned REG_SEL  = 1;
   localparam int unsigned REG_LO   = 2;
   localparam int unsigned REG_HI   = 3;
   localparam int unsigned REG_DONE = 4;

   // command bit positions
   localparam int unsigned CMD_RANGE_BIT = 0;
   localparam int unsigned CMD_ALL_BIT   = 1;
endpackage

// File: rtl/tlbi_entry_bank.sv
module tlbi_entry_bank #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned TAG_W   = 20,
   parameter int unsigned DATA_W  = 32,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush_all,
   input  logic                scan_en,
   input  logic [IDX_W-1:0]    scan_idx,
   input  logic [DATA_W-1:0]   win_lo,
   input  logic [DATA_W-1:0]   win_hi,
   input  logic                fill_en,
   input  logic [IDX_W-1:0]    fill_idx,
   input  logic [TAG_W-1:0]    fill_tag,
   output logic [ENTRIES-1:0]  valid
);
   logic [TAG_W-1:0]  tag_q [ENTRIES];
   logic [TAG_W-1:0]  cur_tag;
   logic [DATA_W-1:0] cur_ext;
   logic              scan_hit;

   // one comparator pair per instance: the tag under the scan pointer
   always_comb begin
      cur_tag = '0;
      for (int e = 0; e < ENTRIES; e++)
         if (scan_idx == IDX_W'(e)) cur_tag = tag_q[e];
      cur_ext  = DATA_W'(cur_tag);
      scan_hit = scan_en && (cur_ext >= win_lo) && (cur_ext <= win_hi);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= '0;
         for (int e = 0; e < ENTRIES; e++) tag_q[e] <= '0;
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (fill_en && fill_idx == IDX_W'(e)) begin
               valid[e] <= 1'b1;
               tag_q[e] <= fill_tag;
            end else if (flush_all) begin
               valid[e] <= 1'b0;
            end else if (scan_hit && scan_idx == IDX_W'(e)) begin
               valid[e] <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/tlbi_scan_seq.sv
module tlbi_scan_seq #(
   parameter int unsigned ENTRIES  = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_INST = 2,
   localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_range,
   input  logic                abort,
   input  logic                clr_done,
   input  logic [DATA_W-1:0]   lo_in,
   input  logic [DATA_W-1:0]   hi_in,
   input  logic [NUM_INST-1:0] sel_in,
   output logic                busy,
   output logic [IDX_W-1:0]    cur_idx,
   output logic [DATA_W-1:0]   scan_lo,
   output logic [DATA_W-1:0]   scan_hi,
   output logic [NUM_INST-1:0] scan_sel,
   output logic                done_flag
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cur_idx   <= '0;
         scan_lo   <= '0;
         scan_hi   <= '0;
         scan_sel  <= '0;
         done_flag <= 1'b0;
      end else begin
         if (clr_done) done_flag <= 1'b0;
         if (abort) begin
            busy    <= 1'b0;
            cur_idx <= '0;
         end else if (start_range) begin
            busy      <= 1'b1;
            cur_idx   <= '0;
            scan_lo   <= lo_in;
            scan_hi   <= hi_in;
            scan_sel  <= sel_in;
            done_flag <= 1'b0;
         end else if (busy) begin
            if (cur_idx == LAST_IDX) begin
               busy      <= 1'b0;
               cur_idx   <= '0;
               done_flag <= 1'b1;
            end else begin
               cur_idx <= cur_idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tlbi_ctrl.sv
module tlbi_ctrl #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned TAG_W   = 20,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3,
   localparam int unsigned NINST  = tlbi_pkg::NUM_INST,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   input  logic                     fill_en,
   input  logic                     fill_inst,
   input  logic [IDX_W-1:0]         fill_idx,
   input  logic [TAG_W-1:0]         fill_tag,
   output logic [NINST*ENTRIES-1:0] valid_o
);
   import tlbi_pkg::*;

   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(REG_CMD);
   localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(REG_SEL);
   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(REG_LO);
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(REG_HI);
   localparam logic [ADDR_W-1:0] A_DONE = ADDR_W'(REG_DONE);

   generate
      if (ENTRIES < 2)      begin : g_chk_ent  $error("ENTRIES must be at least 2");      end
      if (TAG_W > DATA_W)   begin : g_chk_tag  $error("TAG_W must not exceed DATA_W");    end
      if (ADDR_W < 3)       begin : g_chk_addr $error("ADDR_W must be at least 3");       end
      if (DATA_W < NINST)   begin : g_chk_dat  $error("DATA_W too narrow for selection"); end
   endgenerate

   logic [NINST-1:0]  sel_q;
   logic [DATA_W-1:0] lo_q, hi_q;
   logic              cmd_wr, full_cmd, range_cmd, clr_done;
   logic              busy, done_flag;
   logic [IDX_W-1:0]  cur_idx;
   logic [DATA_W-1:0] scan_lo, scan_hi;
   logic [NINST-1:0]  scan_sel;

   assign cmd_wr    = wr_en && (addr == A_CMD);
   assign full_cmd  = cmd_wr && wdata[CMD_ALL_BIT];
   assign range_cmd = cmd_wr && wdata[CMD_RANGE_BIT] && !wdata[CMD_ALL_BIT];
   assign clr_done  = wr_en && (addr == A_DONE) && (wdata == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         lo_q  <= '0;
         hi_q  <= '0;
      end else if (wr_en) begin
         if (addr == A_SEL) sel_q <= wdata[NINST-1:0];
         if (addr == A_LO)  lo_q  <= wdata;
         if (addr == A_HI)  hi_q  <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_SEL:   rdata = DATA_W'(sel_q);
         A_LO:    rdata = lo_q;
         A_HI:    rdata = hi_q;
         A_DONE:  rdata = DATA_W'(done_flag);
         default: rdata = '0;
      endcase
   end

   tlbi_scan_seq #(
      .ENTRIES (ENTRIES),
      .DATA_W  (DATA_W),
      .NUM_INST(NINST)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_range(range_cmd),
      .abort      (full_cmd),
      .clr_done   (clr_done),
      .lo_in      (lo_q),
      .hi_in      (hi_q),
      .sel_in     (sel_q),
      .busy       (busy),
      .cur_idx    (cur_idx),
      .scan_lo    (scan_lo),
      .scan_hi    (scan_hi),
      .scan_sel   (scan_sel),
      .done_flag  (done_flag)
   );

   generate
      for (genvar i = 0; i < NINST; i++) begin : g_bank
         logic bank_fill;
         assign bank_fill = fill_en && (fill_inst == 1'(i));
         tlbi_entry_bank #(
            .ENTRIES(ENTRIES),
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
         ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush_all(full_cmd && sel_q[i]),
            .scan_en  (busy && scan_sel[i]),
            .scan_idx (cur_idx),
            .win_lo   (scan_lo),
            .win_hi   (scan_hi),
            .fill_en  (bank_fill),
            .fill_idx (fill_idx),
            .fill_tag (fill_tag),
            .valid    (valid_o[i*ENTRIES +: ENTRIES])
         );
      end
   endgenerate
endmodule

// File: rtl/tlbi_ctrl_chk.sv
module tlbi_ctrl_chk #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned IDX_W   = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_en,
   input logic [ADDR_W-1:0]      addr,
   input logic [DATA_W-1:0]      wdata,
   input logic                   fill_en,
   input logic                   fill_inst,
   input logic [IDX_W-1:0]       fill_idx,
   input logic [2*ENTRIES-1:0]   valid_o,
   input logic [1:0]             sel_q,
   input logic                   busy,
   input logic                   done_flag
);
   logic full_wr, done_zero_wr;
   assign full_wr      = wr_en && (addr == ADDR_W'(0)) && wdata[1];
   assign done_zero_wr = wr_en && (addr == ADDR_W'(4)) && (wdata == '0);

   AST_FULL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      full_wr && sel_q[0] && !(fill_en && !fill_inst) |=> valid_o[ENTRIES-1:0] == '0); // R3

   AST_FULL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      full_wr && !done_flag |=> !done_flag); // R3

   AST_UNSEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      full_wr && !sel_q[1] && !busy && !fill_en |=> $stable(valid_o[2*ENTRIES-1:ENTRIES])); // R4

   AST_DONE_FROM_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> $past(busy)); // R6

   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      done_zero_wr && !busy |=> !done_flag); // R7

   AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      full_wr |=> !busy); // R8

   AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> valid_o[{$past(fill_inst), $past(fill_idx)}]); // R10
endmodule

bind tlbi_ctrl tlbi_ctrl_chk #(
   .ENTRIES(ENTRIES),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .fill_en  (fill_en),
   .fill_inst(fill_inst),
   .fill_idx (fill_idx),
   .valid_o  (valid_o),
   .sel_q    (sel_q),
   .busy     (busy),
   .done_flag(done_flag)
);

// File: tb/tlbi_ctrl_tb.sv
`timescale 1ns/1ps
module tlbi_ctrl_tb;
   localparam int ENT = 8;
   localparam int TW  = 20;
   localparam int DW  = 32;
   localparam int AW  = 3;
   localparam int IW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          fill_en = 1'b0;
   logic          fill_inst = 1'b0;
   logic [IW-1:0] fill_idx = '0;
   logic [TW-1:0] fill_tag = '0;
   logic [2*ENT-1:0] valid_o;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   tlbi_ctrl #(.ENTRIES(ENT), .TAG_W(TW), .DATA_W(DW), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .fill_en(fill_en), .fill_inst(fill_inst),
      .fill_idx(fill_idx), .fill_tag(fill_tag), .valid_o(valid_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input int a, input logic [31:0] d);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      addr = AW'(a); #1; d = rdata;
   endtask

   task automatic fill(input bit inst, input int idx, input int tag);
      fill_en = 1'b1; fill_inst = inst; fill_idx = IW'(idx); fill_tag = TW'(tag);
      @(posedge clk); @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic fill_both();
      for (int e = 0; e < ENT; e++) begin
         fill(1'b0, e, e * 16);
         fill(1'b1, e, e * 16);
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 valid", 32'(valid_o), 0);
      rd(4, d); chk("R1 done", d, 0);
      rd(1, d); chk("R1 sel", d, 0);
      rd(2, d); chk("R1 lo", d, 0);
      rd(3, d); chk("R1 hi", d, 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(1, 3); wr(2, 32'h123); wr(3, 32'habc);
      rd(1, d); chk("R2 sel", d, 3);
      rd(2, d); chk("R2 lo", d, 32'h123);
      rd(3, d); chk("R2 hi", d, 32'habc);
      rd(0, d); chk("R2 cmd reads 0", d, 0);
   endtask

   task automatic t_full();
      logic [31:0] d;
      fill_both();
      chk("R10 fill sets valid", 32'(valid_o), 32'hffff);
      wr(1, 1); wr(0, 2);
      chk("R3 inst0 cleared", 32'(valid_o[7:0]), 0);
      chk("R4 inst1 kept", 32'(valid_o[15:8]), 32'hff);
      rd(4, d); chk("R3 no done", d, 0);
      wr(1, 2); wr(0, 3);
      chk("R3 value 3 flushes inst1", 32'(valid_o[15:8]), 0);
      fill_both();
      wr(1, 3); wr(0, 0);
      chk("R3 cmd 0 no effect", 32'(valid_o), 32'hffff);
   endtask

   task automatic t_range();
      logic [31:0] d;
      fill_both();
      wr(1, 3); wr(2, 32'h20); wr(3, 32'h50);
      wr(0, 1);
      for (int j = 1; j < ENT; j++) begin
         @(negedge clk);
         rd(4, d); chk("R6 not done early", d, 0);
      end
      @(negedge clk);
      rd(4, d); chk("R6 done at ENTRIES", d, 1);
      chk("R5 inst0 window", 32'(valid_o[7:0]), 32'hc3);
      chk("R5 inst1 window", 32'(valid_o[15:8]), 32'hc3);
      fill_both();
      wr(1, 1); wr(2, 0); wr(3, 0); wr(0, 1);
      repeat (ENT) @(negedge clk);
      chk("R4 range inst0", 32'(valid_o[7:0]), 32'hfe);
      chk("R4 range inst1 kept", 32'(valid_o[15:8]), 32'hff);
   endtask

   task automatic t_done();
      logic [31:0] d;
      rd(4, d); chk("R7 done set", d, 1);
      wr(4, 5); rd(4, d); chk("R7 nonzero ignored", d, 1);
      wr(4, 0); rd(4, d); chk("R7 zero clears", d, 0);
      wr(2, 32'h100); wr(3, 32'h100); wr(0, 1);
      repeat (ENT) @(negedge clk);
      rd(4, d); chk("R7 done again", d, 1);
      wr(0, 1); rd(4, d); chk("R7 new range clears", d, 0);
      repeat (ENT) @(negedge clk);
   endtask

   task automatic t_abort();
      logic [31:0] d;
      fill_both();
      wr(1, 3); wr(2, 0); wr(3, 32'hfffff); wr(0, 1);
      repeat (2) @(negedge clk);
      wr(0, 2);
      chk("R8 full flush wins", 32'(valid_o), 0);
      repeat (2 * ENT) @(negedge clk);
      rd(4, d); chk("R8 no done after abort", d, 0);
   endtask

   task automatic t_restart();
      logic [31:0] d;
      fill_both();
      wr(1, 3); wr(2, 32'h60); wr(3, 32'h70); wr(0, 1);
      wr(2, 0); wr(3, 32'h10); wr(0, 1);
      repeat (ENT - 1) @(negedge clk);
      rd(4, d); chk("R9 not done before restart count", d, 0);
      @(negedge clk);
      rd(4, d); chk("R9 done after restart", d, 1);
      chk("R9 inst0 new window", 32'(valid_o[7:0]), 32'hfc);
      chk("R9 inst1 new window", 32'(valid_o[15:8]), 32'hfc);
   endtask

   task automatic t_fill_race();
      fill_both();
      wr(1, 1); wr(2, 0); wr(3, 32'h70); wr(0, 1);
      repeat (3) @(negedge clk);
      fill(1'b0, 3, 32'h30);
      repeat (4) @(negedge clk);
      chk("R10 fill beats scan", 32'(valid_o[7:0]), 32'h08);
      wr_en = 1'b1; addr = AW'(0); wdata = 2;
      fill_en = 1'b1; fill_inst = 1'b0; fill_idx = IW'(5); fill_tag = TW'(32'h55);
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; wdata = '0; fill_en = 1'b0;
      chk("R10 fill beats flush", 32'(valid_o[7:0]), 32'h20);
   endtask

   initial begin
      #(20000 * 5);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_full();
      t_range();
      t_done();
      t_abort();
      t_restart();
      t_fill_race();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule